// File: doc/BRIEF.md
# Terminal Character Register Port

This block sits between a processor's I/O bus and a character terminal line. It gives the processor eight register addresses. The lower four belong to a receive half and the upper four to a transmit half. The receive half captures characters strobed in from the line, but only while software has switched the receiver on. It keeps the character for a later read and can request an interrupt. The transmit half takes a character from a bus write and offers it on a valid/ready handshake until the line accepts it. It then reports completion in its status word and can request an interrupt of its own.

Bit timing, parity and interrupt arbitration are handled elsewhere. The block's interrupt outputs are one-cycle pulses, each carrying a fixed level number: 12 for receive and 10 for transmit.

Bus reads are combinational: `ioRdata` shows the selected register while `ioRd` is high. All side effects of a read or a write take place at the next rising clock edge.

Top module: `ttyRegPort`

## Requirements
- R1: After reset, the transmit status word reads 0x0008 (ready set, idle), the receive status word reads 0x0000, `txValid` is low, and no interrupt pulse is present.
- R2: Address 2 reads the receive status word and address 6 reads the transmit status word. Reads at addresses 1, 3, 4, 5 and 7 return zero. Writes to addresses 1 and 4 change no register.
- R3: A write to address 3 loads the receive control bits. Bit 0 enables the receive interrupt, bit 1 enables the error interrupt (stored only), and bit 2 switches the receiver on. Receive status bit 0 then equals the new bit 0.
- R4: While the receiver is on, a `rxValid` strobe stores `rxChar[6:0]` and sets receive status bit 3 (character waiting). While it is off, the strobe is dropped: the stored character and bit 3 are unchanged.
- R5: A read at address 0 returns the stored 7-bit character, zero-extended, and clears receive status bit 3.
- R6: A stored character with receive control bit 0 set produces exactly one `irqRx` pulse in the cycle after the strobe, with `irqRxLevel` = 12.
- R7: A write to address 5 keeps the low 7 bits as the transmit character. It clears transmit status bit 3 (ready), sets bit 2 (active), and raises `txValid` from the next cycle.
- R8: While `txReady` is low, `txValid` stays high, `txChar` holds its value, and transmit status bit 2 stays set.
- R9: The cycle after `txValid` and `txReady` are both high, `txValid` is low, transmit status bit 2 is clear and bit 3 is set. If transmit status bit 0 is set, exactly one `irqTx` pulse with `irqTxLevel` = 10 appears in that cycle.
- R10: A write to address 7 copies only written bits 1:0 into transmit status bits 1:0. Bits 3:2 are untouched.
- R11: If a read at address 0 and an accepted `rxValid` strobe fall in the same cycle, the read returns the old character, the new character is stored, and bit 3 stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ioSel | input | 3 | Register address |
| ioRd | input | 1 | Read strobe |
| ioWr | input | 1 | Write strobe |
| ioWdata | input | 16 | Write data |
| ioRdata | output | 16 | Read data (combinational) |
| rxValid | input | 1 | Received character strobe |
| rxChar | input | 8 | Received character |
| txValid | output | 1 | Transmit character offered |
| txChar | output | 7 | Transmit character |
| txReady | input | 1 | Line accepts the character |
| irqRx | output | 1 | Receive interrupt pulse |
| irqRxLevel | output | 4 | Receive interrupt level, 12 during the pulse, else 0 |
| irqTx | output | 1 | Transmit interrupt pulse |
| irqTxLevel | output | 4 | Transmit interrupt level, 10 during the pulse, else 0 |

## Verification
Some properties are checked on every cycle. The transmit character holds while the line stalls. Active and ready are never set together in the transmit status. A transmit write starts a transfer, and a completed handshake ends one. A read clears the waiting flag, and the stored character changes only on an accepted strobe. An interrupt pulse appears only one cycle after its cause.

Other behaviour can only be shown by the bench's scenarios. These include the address map, the zero reads and ignored writes at unused addresses, and the mirror of the interrupt enable. They also include stripping of bit 7, dropping while the receiver is off, and a read colliding with an arrival. A scoreboard checks that each interrupt and each transmitted character appears once, with the right level or value.

// File: rtl/ttyPkg.sv
package ttyPkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_RX_DATA = 3'd0;
  localparam logic [SEL_W-1:0] SEL_RX_STAT = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RX_CTRL = 3'd3;
  localparam logic [SEL_W-1:0] SEL_TX_DATA = 3'd5;
  localparam logic [SEL_W-1:0] SEL_TX_STAT = 3'd6;
  localparam logic [SEL_W-1:0] SEL_TX_CTRL = 3'd7;

  localparam int CTL_IRQ_BIT = 0;
  localparam int CTL_ERR_BIT = 1;
  localparam int CTL_ON_BIT  = 2;
  localparam int ST_BUSY_BIT = 2;
  localparam int ST_RDY_BIT  = 3;

  typedef struct packed {
    logic rdData;
    logic wrInCtrl;
    logic wrTxData;
    logic wrOutCtrl;
    logic rxAccept;
    logic txDone;
  } ttyStrb_t;
endpackage

// File: rtl/ttyCtrl.sv
module ttyCtrl
  import ttyPkg::*;
#(
  parameter int LVL_W    = 4,
  parameter int RX_LEVEL = 12,
  parameter int TX_LEVEL = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] ioSel,
  input  logic             ioRd,
  input  logic             ioWr,
  input  logic             rxValid,
  input  logic             txValid,
  input  logic             txReady,
  input  logic             rxActive,
  input  logic             rxIrqEn,
  input  logic             txIrqEn,
  output ttyStrb_t         strb,
  output logic             irqRx,
  output logic [LVL_W-1:0] irqRxLevel,
  output logic             irqTx,
  output logic [LVL_W-1:0] irqTxLevel
);
  localparam logic [LVL_W-1:0] RX_LVL = LVL_W'(RX_LEVEL);
  localparam logic [LVL_W-1:0] TX_LVL = LVL_W'(TX_LEVEL);

  always_comb begin
    strb.rdData    = ioRd && (ioSel == SEL_RX_DATA);
    strb.wrInCtrl  = ioWr && (ioSel == SEL_RX_CTRL);
    strb.wrTxData  = ioWr && (ioSel == SEL_TX_DATA);
    strb.wrOutCtrl = ioWr && (ioSel == SEL_TX_CTRL);
    strb.rxAccept  = rxValid && rxActive;
    strb.txDone    = txValid && txReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqRx <= 1'b0;
      irqTx <= 1'b0;
    end else begin
      irqRx <= strb.rxAccept && rxIrqEn;
      irqTx <= strb.txDone && txIrqEn;
    end
  end

  assign irqRxLevel = irqRx ? RX_LVL : '0;
  assign irqTxLevel = irqTx ? TX_LVL : '0;

  // R6
  rx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqRx |-> $past(rxValid && rxActive && rxIrqEn));

  // R9
  tx_irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqTx |-> $past(txValid && txReady && txIrqEn));
endmodule

// File: rtl/ttyDatapath.sv
module ttyDatapath
  import ttyPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAR_W = 7,
  parameter int RXIN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ttyStrb_t          strb,
  input  logic [SEL_W-1:0]  ioSel,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  input  logic [RXIN_W-1:0] rxChar,
  output logic              txValid,
  output logic [CHAR_W-1:0] txChar,
  output logic              rxActive,
  output logic              rxIrqEn,
  output logic              txIrqEn
);
  localparam int CTL_W = 3;

  logic [CHAR_W-1:0] rxData;
  logic              inReady;
  logic [CTL_W-1:0]  inCtrl;
  logic [CHAR_W-1:0] txData;
  logic [1:0]        outCtlBits;
  logic              txBusy;
  logic              outReady;
  logic [DATA_W-1:0] inStatus;
  logic [DATA_W-1:0] outStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      inReady <= 1'b0;
      inCtrl  <= '0;
    end else begin
      if (strb.rxAccept) begin
        rxData  <= rxChar[CHAR_W-1:0];
        inReady <= 1'b1;
      end else if (strb.rdData) begin
        inReady <= 1'b0;
      end
      if (strb.wrInCtrl) inCtrl <= ioWdata[CTL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData     <= '0;
      outCtlBits <= '0;
      txBusy     <= 1'b0;
      outReady   <= 1'b1;
    end else begin
      if (strb.wrTxData) begin
        txData   <= ioWdata[CHAR_W-1:0];
        txBusy   <= 1'b1;
        outReady <= 1'b0;
      end else if (strb.txDone) begin
        txBusy   <= 1'b0;
        outReady <= 1'b1;
      end
      if (strb.wrOutCtrl) outCtlBits <= ioWdata[1:0];
    end
  end

  always_comb begin
    inStatus                = '0;
    inStatus[CTL_IRQ_BIT]   = inCtrl[CTL_IRQ_BIT];
    inStatus[ST_RDY_BIT]    = inReady;
    outStatus               = '0;
    outStatus[1:0]          = outCtlBits;
    outStatus[ST_BUSY_BIT]  = txBusy;
    outStatus[ST_RDY_BIT]   = outReady;
  end

  always_comb begin
    case (ioSel)
      SEL_RX_DATA: ioRdata = DATA_W'(rxData);
      SEL_RX_STAT: ioRdata = inStatus;
      SEL_TX_STAT: ioRdata = outStatus;
      default:     ioRdata = '0;
    endcase
  end

  assign txValid  = txBusy;
  assign txChar   = txData;
  assign rxActive = inCtrl[CTL_ON_BIT];
  assign rxIrqEn  = inCtrl[CTL_IRQ_BIT];
  assign txIrqEn  = outCtlBits[CTL_IRQ_BIT];

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !strb.txDone && !strb.wrTxData) |=> txBusy && $stable(txData));

  // R9
  tx_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txDone && !strb.wrTxData) |=> (outReady && !txBusy));

  // R7
  tx_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTxData |=> (txBusy && !outReady && txData == $past(ioWdata[CHAR_W-1:0])));

  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdData && !strb.rxAccept) |=> !inReady);

  // R4
  rx_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rxAccept |=> $stable(rxData));

  // R1
  busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txBusy && outReady));
endmodule

// File: rtl/ttyRegPort.sv
module ttyRegPort
  import ttyPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CHAR_W   = 7,
  parameter int RXIN_W   = 8,
  parameter int LVL_W    = 4,
  parameter int RX_LEVEL = 12,
  parameter int TX_LEVEL = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        ioSel,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata,
  input  logic              rxValid,
  input  logic [RXIN_W-1:0] rxChar,
  output logic              txValid,
  output logic [CHAR_W-1:0] txChar,
  input  logic              txReady,
  output logic              irqRx,
  output logic [LVL_W-1:0]  irqRxLevel,
  output logic              irqTx,
  output logic [LVL_W-1:0]  irqTxLevel
);
  ttyStrb_t strb;
  logic     rxActive;
  logic     rxIrqEn;
  logic     txIrqEn;

  ttyCtrl #(.LVL_W(LVL_W), .RX_LEVEL(RX_LEVEL), .TX_LEVEL(TX_LEVEL)) i_ctrl (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioRd(ioRd), .ioWr(ioWr),
    .rxValid(rxValid), .txValid(txValid), .txReady(txReady),
    .rxActive(rxActive), .rxIrqEn(rxIrqEn), .txIrqEn(txIrqEn),
    .strb(strb), .irqRx(irqRx), .irqRxLevel(irqRxLevel),
    .irqTx(irqTx), .irqTxLevel(irqTxLevel)
  );

  ttyDatapath #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .RXIN_W(RXIN_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioSel(ioSel), .ioWdata(ioWdata),
    .ioRdata(ioRdata), .rxChar(rxChar), .txValid(txValid), .txChar(txChar),
    .rxActive(rxActive), .rxIrqEn(rxIrqEn), .txIrqEn(txIrqEn)
  );
endmodule

// File: tb/test_ttyRegPort.sv
module test_ttyRegPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  ioSel = '0;
  logic        ioRd = 1'b0;
  logic        ioWr = 1'b0;
  logic [15:0] ioWdata = '0;
  logic [15:0] ioRdata;
  logic        rxValid = 1'b0;
  logic [7:0]  rxChar = '0;
  logic        txValid;
  logic [6:0]  txChar;
  logic        txReady = 1'b0;
  logic        irqRx;
  logic [3:0]  irqRxLevel;
  logic        irqTx;
  logic [3:0]  irqTxLevel;

  int vecs = 0;
  int fails = 0;
  int expIrq[$];
  int expTx[$];
  logic [15:0] rd;

  always #2.5 clk = ~clk;

  ttyRegPort i_ttyRegPort (
    .clk(clk), .rstN(rstN), .ioSel(ioSel), .ioRd(ioRd), .ioWr(ioWr),
    .ioWdata(ioWdata), .ioRdata(ioRdata), .rxValid(rxValid), .rxChar(rxChar),
    .txValid(txValid), .txChar(txChar), .txReady(txReady),
    .irqRx(irqRx), .irqRxLevel(irqRxLevel), .irqTx(irqTx), .irqTxLevel(irqTxLevel)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    ioSel = sel; ioWdata = d; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] sel, output logic [15:0] d);
    @(negedge clk);
    ioSel = sel; ioRd = 1'b1;
    #1 d = ioRdata;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic rxSend(input logic [7:0] ch, input bit irqExp);
    @(negedge clk);
    rxValid = 1'b1; rxChar = ch;
    if (irqExp) expIrq.push_back(12);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // Monitor: pops the scoreboard as the design produces pulses and characters
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (irqRx) begin
        if (expIrq.size() == 0) checkEq("R6 unexpected rx irq", 1, 0);
        else checkEq("R6 rx irq level", int'(irqRxLevel), expIrq.pop_front());
      end
      if (irqTx) begin
        if (expIrq.size() == 0) checkEq("R9 unexpected tx irq", 1, 0);
        else checkEq("R9 tx irq level", int'(irqTxLevel), expIrq.pop_front());
      end
      if (txValid && txReady) begin
        if (expTx.size() == 0) checkEq("R7 unexpected tx char", 1, 0);
        else checkEq("R7 tx char", int'(txChar), expTx.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    busRead(3'd2, rd); checkEq("R1 rx status", rd, 16'h0000);
    busRead(3'd6, rd); checkEq("R1 tx status", rd, 16'h0008);
    checkEq("R1 txValid", txValid, 0);
    // R4 drop while receiver off
    busWrite(3'd3, 16'h0000);
    rxSend(8'h41, 0);
    busRead(3'd2, rd); checkEq("R4 drop no ready", rd, 16'h0000);
    busRead(3'd0, rd); checkEq("R4 drop keeps data", rd, 16'h0000);
    // R3 control write, mirror
    busWrite(3'd3, 16'h0005);
    busRead(3'd2, rd); checkEq("R3 mirror set", rd, 16'h0001);
    // R4 store low 7 bits, R6 irq
    rxSend(8'hC1, 1);
    busRead(3'd2, rd); checkEq("R4 ready set", rd, 16'h0009);
    // R5 read clears ready
    busRead(3'd0, rd); checkEq("R5 data low7", rd, 16'h0041);
    busRead(3'd2, rd); checkEq("R5 ready cleared", rd, 16'h0001);
    // R3 mirror clears, no irq when disabled
    busWrite(3'd3, 16'h0004);
    busRead(3'd2, rd); checkEq("R3 mirror clear", rd, 16'h0000);
    rxSend(8'h33, 0);
    busRead(3'd2, rd); checkEq("R4 ready no irq", rd, 16'h0008);
    busRead(3'd0, rd); checkEq("R5 data", rd, 16'h0033);
    // R4 dropped while off keeps old char
    busWrite(3'd3, 16'h0000);
    rxSend(8'h22, 0);
    busRead(3'd2, rd); checkEq("R4 off no ready", rd, 16'h0000);
    busRead(3'd0, rd); checkEq("R4 off keeps char", rd, 16'h0033);
    // R11 read collides with arrival
    busWrite(3'd3, 16'h0004);
    rxSend(8'h10, 0);
    @(negedge clk);
    ioSel = 3'd0; ioRd = 1'b1; rxValid = 1'b1; rxChar = 8'h11;
    #1 rd = ioRdata;
    @(negedge clk);
    ioRd = 1'b0; rxValid = 1'b0;
    checkEq("R11 old char read", rd, 16'h0010);
    busRead(3'd2, rd); checkEq("R11 ready kept", rd, 16'h0008);
    busRead(3'd0, rd); checkEq("R11 new char", rd, 16'h0011);
    // R2 ignored addresses
    busWrite(3'd1, 16'hFFFF);
    busWrite(3'd4, 16'hFFFF);
    busRead(3'd2, rd); checkEq("R2 rx status untouched", rd, 16'h0000);
    busRead(3'd6, rd); checkEq("R2 tx status untouched", rd, 16'h0008);
    checkEq("R2 no tx start", txValid, 0);
    busRead(3'd1, rd); checkEq("R2 read addr1 zero", rd, 16'h0000);
    busRead(3'd3, rd); checkEq("R2 read addr3 zero", rd, 16'h0000);
    // R10 output control write
    busWrite(3'd7, 16'hFFFE);
    busRead(3'd6, rd); checkEq("R10 bits1:0 only a", rd, 16'h000A);
    busWrite(3'd7, 16'h0001);
    busRead(3'd6, rd); checkEq("R10 bits1:0 only b", rd, 16'h0009);
    // R7/R8 transmit with stall
    txReady = 1'b0;
    expTx.push_back(7'h45);
    expIrq.push_back(10);
    busWrite(3'd5, 16'h01C5);
    busRead(3'd6, rd); checkEq("R7 active not ready", rd, 16'h0005);
    repeat (4) @(negedge clk);
    #1;
    checkEq("R8 valid held", txValid, 1);
    checkEq("R8 char held", txChar, 7'h45);
    busRead(3'd6, rd); checkEq("R8 still active", rd, 16'h0005);
    // R9 completion
    @(negedge clk); txReady = 1'b1;
    @(negedge clk); #1;
    checkEq("R9 valid dropped", txValid, 0);
    busRead(3'd6, rd); checkEq("R9 ready again", rd, 16'h0009);
    // R9 no irq when disabled
    busWrite(3'd7, 16'h0000);
    expTx.push_back(7'h7F);
    busWrite(3'd5, 16'h00FF);
    repeat (3) @(negedge clk);
    busRead(3'd6, rd); checkEq("R9 done no irq", rd, 16'h0008);
    repeat (3) @(negedge clk);
    checkEq("R6 R9 irq queue drained", expIrq.size(), 0);
    checkEq("R7 tx queue drained", expTx.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule